// File: doc/BRIEF.md
# UART Channel FIFO Control with DMA Readiness

This block is the FIFO control for one channel of a 16550-class UART. A host writes a one-byte, write-only control register over a simple write strobe. The register switches two 16-entry, 8-bit character queues on or off, one queue for transmit and one for receive. It also empties either queue on request, selects one of two DMA signalling modes and picks a receive trigger level. Push and pop ports stand in for the serial shift paths: the transmitter pops characters from the transmit queue, and the receiver pushes characters into the receive queue.

From the queue occupancies the block derives two active-low DMA request lines, `txRdyN` and `rxRdyN`, and a receive trigger interrupt. In mode 0 the DMA lines follow simple empty and non-empty conditions. In mode 1 they switch to block transfers: transmit requests until the queue is full, and receive requests once the trigger level is reached or a time-out strobe arrives, then keeps requesting until the queue drains. When the queues are switched off, each direction shrinks to a single holding register.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the control register is all zeros, both counts are 0, `txRdyN` is 0, `rxRdyN` is 1, and `rxTrigIrq` and `rxOverrun` are 0.
- R2: A control write with bit 0 = 0 turns the queues off and ignores bits 7:1 of that write. In particular, bits 1 and 2 clear nothing.
- R3: A control write with bits 0 and 1 both set empties the receive queue at that same clock edge and leaves the transmit queue as it is. The clear does not persist: a later write with bit 1 = 0 clears nothing.
- R4: A control write with bits 0 and 2 both set empties the transmit queue at that same edge and leaves the receive queue as it is.
- R5: A write that changes the enable state (bit 0) empties both queues.
- R6: Capacity is 16 with the queues on and 1 with them off. A push into a full queue is dropped and the count is unchanged.
- R7: A receive push into a full queue raises `rxOverrun` for exactly the one cycle after the push.
- R8: Characters leave in arrival order. The head port shows the oldest stored character.
- R9: Bits 7:6 select the trigger level: 00 = 1, 01 = 4, 10 = 8, 11 = 14. With the queues off the level is 1. `rxTrigIrq` is high while the receive count is at or above the level.
- R10: In mode 0 (bit 3 = 0), or with the queues off, `txRdyN` is low exactly when the transmit count is 0, and `rxRdyN` is low exactly when the receive count is non-zero.
- R11: In mode 1 (bit 3 = 1, queues on), `txRdyN` is high exactly when the transmit queue holds 16 characters.
- R12: In mode 1, `rxRdyN` goes low when the receive count reaches the trigger level. It stays low as pops take the count below the level, and returns high when the count reaches 0.
- R13: In mode 1, a one-cycle `rxTimeout` pulse while the receive queue is non-empty drives `rxRdyN` low from the next cycle, until the queue empties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Control register write strobe |
| cfgData | input | 8 | Control register write data |
| txPush | input | 1 | Host writes a transmit character |
| txData | input | 8 | Transmit character in |
| txPop | input | 1 | Transmit shift path takes the head character |
| txHead | output | 8 | Oldest transmit character |
| txCount | output | 5 | Transmit occupancy |
| rxPush | input | 1 | Receive shift path delivers a character |
| rxData | input | 8 | Received character in |
| rxPop | input | 1 | Host reads the head character |
| rxHead | output | 8 | Oldest received character |
| rxCount | output | 5 | Receive occupancy |
| rxTimeout | input | 1 | Receive time-out strobe |
| txRdyN | output | 1 | Active-low transmit DMA request |
| rxRdyN | output | 1 | Active-low receive DMA request |
| rxTrigIrq | output | 1 | Receive trigger-level interrupt |
| rxOverrun | output | 1 | Pulse for a receive push into a full queue |

## Verification
The trigger logic is driven from a table that sets each of the four level codes and fills the receive queue to one short of the level and then exactly to it. This separates a comparison that is off by one from a level decoded from the wrong code. Further rows use mode 0 and the disabled state with the same fills, so a request line that ignores the mode bit or the enable bit shows up. Directed sequences fill the transmit queue to capacity and switch modes without a flush, drain the receive queue across its level, and pulse the time-out. These tell apart a sticky mode-1 request from a level-following one, and a self-clearing reset bit from one that persists.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  // Strobes and settings handed from the control register to the queues.
  typedef struct packed {
    logic txClr;   // empty the transmit queue this cycle
    logic rxClr;   // empty the receive queue this cycle
    logic fifoEn;  // queues on (full depth) or off (single holding register)
  } fifoCtl_t;
endpackage

// File: rtl/uart_fifo_store.sv
module uart_fifo_store #(
  parameter int W = 8,
  parameter int DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           clr,
  input  logic [$clog2(DEPTH+1)-1:0]     cap,
  input  logic                           push,
  input  logic [W-1:0]                   wrData,
  input  logic                           pop,
  output logic [W-1:0]                   head,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign doPush = push && (count < cap);
  assign doPop  = pop && (count != '0);
  assign drop   = push && (count >= cap);
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_fifo_data.sv
module uart_fifo_data
  import uart_fifo_pkg::*;
#(
  parameter int W = 8,
  parameter int DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  fifoCtl_t                       ctl,
  input  logic                           txPush,
  input  logic [W-1:0]                   txData,
  input  logic                           txPop,
  output logic [W-1:0]                   txHead,
  output logic [$clog2(DEPTH+1)-1:0]     txCount,
  input  logic                           rxPush,
  input  logic [W-1:0]                   rxData,
  input  logic                           rxPop,
  output logic [W-1:0]                   rxHead,
  output logic [$clog2(DEPTH+1)-1:0]     rxCount,
  output logic                           rxOverrun
);
  localparam int CW = $clog2(DEPTH+1);
  logic [CW-1:0] cap;
  logic          txDrop, rxDrop;

  assign cap = ctl.fifoEn ? CW'(DEPTH) : CW'(1);

  uart_fifo_store #(.W(W), .DEPTH(DEPTH)) u_txQ (
    .clk(clk), .rstN(rstN), .clr(ctl.txClr), .cap(cap),
    .push(txPush), .wrData(txData), .pop(txPop),
    .head(txHead), .count(txCount), .drop(txDrop)
  );

  uart_fifo_store #(.W(W), .DEPTH(DEPTH)) u_rxQ (
    .clk(clk), .rstN(rstN), .clr(ctl.rxClr), .cap(cap),
    .push(rxPush), .wrData(rxData), .pop(rxPop),
    .head(rxHead), .count(rxCount), .drop(rxDrop)
  );

  // A dropped transmit write is silent; a dropped receive character is flagged.
  logic unusedTxDrop;
  assign unusedTxDrop = txDrop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxOverrun <= 1'b0;
    else       rxOverrun <= rxDrop && !ctl.rxClr;
  end
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgWe,
  input  logic [7:0]                     cfgData,
  input  logic [$clog2(DEPTH+1)-1:0]     txCount,
  input  logic [$clog2(DEPTH+1)-1:0]     rxCount,
  input  logic                           rxTimeout,
  output fifoCtl_t                       ctl,
  output logic                           txRdyN,
  output logic                           rxRdyN,
  output logic                           rxTrigIrq
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic       fifoEnQ, dmaModeQ, rxArmQ, modeOne, enWrite;
  logic [1:0] trigSelQ;
  logic [CW-1:0] trigLvl;

  assign enWrite = cfgWe && cfgData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEnQ  <= 1'b0;
      dmaModeQ <= 1'b0;
      trigSelQ <= 2'b00;
    end else if (cfgWe) begin
      fifoEnQ <= cfgData[0];
      if (cfgData[0]) begin
        dmaModeQ <= cfgData[3];
        trigSelQ <= cfgData[7:6];
      end
    end
  end

  // Clear strobes exist only during the write cycle, so the bits never stick.
  always_comb begin
    ctl.fifoEn = fifoEnQ;
    ctl.rxClr  = (enWrite && cfgData[1]) || (cfgWe && (cfgData[0] != fifoEnQ));
    ctl.txClr  = (enWrite && cfgData[2]) || (cfgWe && (cfgData[0] != fifoEnQ));
  end

  always_comb begin
    if (!fifoEnQ) trigLvl = CW'(1);
    else begin
      case (trigSelQ)
        2'b00:   trigLvl = CW'(1);
        2'b01:   trigLvl = CW'(4);
        2'b10:   trigLvl = CW'(8);
        default: trigLvl = CW'(14);
      endcase
    end
  end

  assign rxTrigIrq = (rxCount >= trigLvl);
  assign modeOne   = fifoEnQ && dmaModeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      rxArmQ <= 1'b0;
    else if (rxCount == '0)         rxArmQ <= 1'b0;
    else if (rxTimeout || rxTrigIrq) rxArmQ <= 1'b1;
  end

  assign txRdyN = modeOne ? (txCount == FULL) : (txCount != '0);
  assign rxRdyN = modeOne ? !((rxArmQ || rxTrigIrq) && (rxCount != '0))
                          : (rxCount == '0);
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int W = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWe,
  input  logic [7:0]                 cfgData,
  input  logic                       txPush,
  input  logic [W-1:0]               txData,
  input  logic                       txPop,
  output logic [W-1:0]               txHead,
  output logic [$clog2(DEPTH+1)-1:0] txCount,
  input  logic                       rxPush,
  input  logic [W-1:0]               rxData,
  input  logic                       rxPop,
  output logic [W-1:0]               rxHead,
  output logic [$clog2(DEPTH+1)-1:0] rxCount,
  input  logic                       rxTimeout,
  output logic                       txRdyN,
  output logic                       rxRdyN,
  output logic                       rxTrigIrq,
  output logic                       rxOverrun
);
  fifoCtl_t ctl;

  uart_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .txCount(txCount), .rxCount(rxCount), .rxTimeout(rxTimeout),
    .ctl(ctl), .txRdyN(txRdyN), .rxRdyN(rxRdyN), .rxTrigIrq(rxTrigIrq)
  );

  uart_fifo_data #(.W(W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .txPush(txPush), .txData(txData), .txPop(txPop),
    .txHead(txHead), .txCount(txCount),
    .rxPush(rxPush), .rxData(rxData), .rxPop(rxPop),
    .rxHead(rxHead), .rxCount(rxCount), .rxOverrun(rxOverrun)
  );
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       cfgWe,
  input logic [7:0]                 cfgData,
  input logic                       rxPush,
  input logic [$clog2(DEPTH+1)-1:0] txCount,
  input logic [$clog2(DEPTH+1)-1:0] rxCount,
  input logic                       txRdyN,
  input logic                       rxRdyN,
  input logic                       rxTrigIrq,
  input logic                       rxOverrun
);
  localparam int CW = $clog2(DEPTH+1);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CW'(DEPTH)) && (rxCount <= CW'(DEPTH)));

  a_r7_overrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |-> $past(rxPush));

  a_r3_rx_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgData[0] && cfgData[1]) |=> (rxCount == '0));

  a_r4_tx_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgData[0] && cfgData[2]) |=> (txCount == '0));

  a_r10_tx_empty_low: assert property (@(posedge clk) disable iff (!rstN)
    (txCount == '0) |-> !txRdyN);

  a_r10_rx_empty_high: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0) |-> rxRdyN);

  a_r9_irq_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    rxTrigIrq |-> (rxCount != '0));
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData), .rxPush(rxPush),
  .txCount(txCount), .rxCount(rxCount), .txRdyN(txRdyN), .rxRdyN(rxRdyN),
  .rxTrigIrq(rxTrigIrq), .rxOverrun(rxOverrun)
);

// File: tb/uart_fifo_ctl_bench.sv
module uart_fifo_ctl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [7:0] cfgData = '0;
  logic txPush = 1'b0, txPop = 1'b0, rxPush = 1'b0, rxPop = 1'b0, rxTimeout = 1'b0;
  logic [7:0] txData = '0, rxData = '0;
  logic [7:0] txHead, rxHead;
  logic [4:0] txCount, rxCount;
  logic txRdyN, rxRdyN, rxTrigIrq, rxOverrun;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_fifo_ctl u_uart_fifo_ctl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .txPush(txPush), .txData(txData), .txPop(txPop), .txHead(txHead), .txCount(txCount),
    .rxPush(rxPush), .rxData(rxData), .rxPop(rxPop), .rxHead(rxHead), .rxCount(rxCount),
    .rxTimeout(rxTimeout), .txRdyN(txRdyN), .rxRdyN(rxRdyN),
    .rxTrigIrq(rxTrigIrq), .rxOverrun(rxOverrun)
  );

  typedef struct packed {
    logic [7:0] cfg;
    logic [7:0] fill;
    logic [7:0] cnt;
    logic       irq;
    logic       rdyN;
  } vec_t;

  // Trigger levels, mode 1 receive request, mode 0 and disabled rows (R9 R10 R12).
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'h09, 8'd0,  8'd0,  1'b0, 1'b1},
    '{8'h09, 8'd1,  8'd1,  1'b1, 1'b0},
    '{8'h49, 8'd3,  8'd3,  1'b0, 1'b1},
    '{8'h49, 8'd4,  8'd4,  1'b1, 1'b0},
    '{8'h89, 8'd7,  8'd7,  1'b0, 1'b1},
    '{8'h89, 8'd8,  8'd8,  1'b1, 1'b0},
    '{8'hC9, 8'd13, 8'd13, 1'b0, 1'b1},
    '{8'hC9, 8'd14, 8'd14, 1'b1, 1'b0},
    '{8'hC9, 8'd18, 8'd16, 1'b1, 1'b0},
    '{8'hC1, 8'd3,  8'd3,  1'b0, 1'b0},
    '{8'h00, 8'd3,  8'd1,  1'b1, 1'b0},
    '{8'h08, 8'd1,  8'd1,  1'b1, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrCfg(input logic [7:0] v);
    cfgWe = 1'b1; cfgData = v;
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic pushTx(input logic [7:0] d);
    txPush = 1'b1; txData = d;
    tick();
    txPush = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] d);
    rxPush = 1'b1; rxData = d;
    tick();
    rxPush = 1'b0;
  endtask

  task automatic popTx();
    txPop = 1'b1; tick(); txPop = 1'b0;
  endtask

  task automatic popRx();
    rxPop = 1'b1; tick(); rxPop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 txCount", txCount, 0);
    chk("R1 rxCount", rxCount, 0);
    chk("R1 txRdyN", txRdyN, 0);
    chk("R1 rxRdyN", rxRdyN, 1);
    chk("R1 rxTrigIrq", rxTrigIrq, 0);
    chk("R1 rxOverrun", rxOverrun, 0);

    // R2: disabled, write with bit0=0 and clear bits set clears nothing
    pushTx(8'h11);
    pushRx(8'h22);
    wrCfg(8'h06);
    chk("R2 txCount kept", txCount, 1);
    chk("R2 rxCount kept", rxCount, 1);
    chk("R10 disabled txRdyN", txRdyN, 1);
    chk("R10 disabled rxRdyN", rxRdyN, 0);

    // R7 overrun pulse, R6 single-entry capacity
    rxPush = 1'b1; rxData = 8'h33;
    tick();
    rxPush = 1'b0;
    chk("R7 overrun pulse", rxOverrun, 1);
    chk("R6 rx disabled cap", rxCount, 1);
    chk("R8 rx head kept", rxHead, 8'h22);
    tick();
    chk("R7 overrun one cycle", rxOverrun, 0);
    pushTx(8'h44);
    chk("R6 tx disabled cap", txCount, 1);

    // R5: enabling flushes both queues
    wrCfg(8'h01);
    chk("R5 enable flush tx", txCount, 0);
    chk("R5 enable flush rx", rxCount, 0);

    // R8 ordering
    pushTx(8'hA1); pushTx(8'hA2); pushTx(8'hA3);
    chk("R8 head oldest", txHead, 8'hA1);
    popTx();
    chk("R8 head next", txHead, 8'hA2);

    // R6 capacity 16 and drop
    for (int i = 0; i < 20; i++) pushTx(8'(i));
    chk("R6 tx full count", txCount, 16);
    chk("R10 mode0 txRdyN full", txRdyN, 1);
    wrCfg(8'h09);
    chk("R11 mode1 full high", txRdyN, 1);
    chk("R5 no flush same enable", txCount, 16);
    popTx();
    chk("R11 mode1 one free low", txRdyN, 0);

    // R4 tx clear leaves rx
    pushRx(8'h51); pushRx(8'h52);
    wrCfg(8'h05);
    chk("R4 tx cleared", txCount, 0);
    chk("R4 rx untouched", rxCount, 2);
    // R3 rx clear leaves tx, bit does not persist
    pushTx(8'h61);
    wrCfg(8'h03);
    chk("R3 rx cleared", rxCount, 0);
    chk("R3 tx untouched", txCount, 1);
    pushRx(8'h71);
    wrCfg(8'h01);
    chk("R3 no sticky clear", rxCount, 1);

    // R12 mode1 sticky receive request, level 4
    wrCfg(8'h4B);
    pushRx(8'h01); pushRx(8'h02); pushRx(8'h03);
    chk("R12 below level", rxRdyN, 1);
    pushRx(8'h04);
    chk("R12 at level", rxRdyN, 0);
    popRx(); popRx();
    chk("R12 below level sticky", rxRdyN, 0);
    chk("R9 irq below level", rxTrigIrq, 0);
    popRx(); popRx();
    chk("R12 empty releases", rxRdyN, 1);

    // R13 time-out
    pushRx(8'h09);
    chk("R13 before timeout", rxRdyN, 1);
    rxTimeout = 1'b1; tick(); rxTimeout = 1'b0;
    chk("R13 after timeout", rxRdyN, 0);
    tick();
    chk("R13 stays low", rxRdyN, 0);
    popRx();
    chk("R13 empty releases", rxRdyN, 1);

    // R5 disable flush
    pushTx(8'h0A);
    wrCfg(8'h08);
    chk("R5 disable flush tx", txCount, 0);

    // Vector walk: R9 R10 R12
    for (int v = 0; v < NV; v++) begin
      wrCfg(8'h03);
      wrCfg(VEC[v].cfg);
      for (int k = 0; k < int'(VEC[v].fill); k++) pushRx(8'(k + 8'h80));
      chk($sformatf("R9 vec%0d count", v), rxCount, int'(VEC[v].cnt));
      chk($sformatf("R9 vec%0d irq", v), rxTrigIrq, VEC[v].irq);
      chk($sformatf("R12 vec%0d rxRdyN", v), rxRdyN, VEC[v].rdyN);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule